// File: doc/BRIEF.md
# Edge-Interval Bit Check Validator

This block judges whether the bit stream coming out of a demodulator is real data or noise. Once enabled, it runs through a fixed start-up period with the data input ignored. It then times every gap between data transitions, counted in sample ticks, against a programmable window. The stream is accepted only if a selectable number of consecutive gaps all fall inside that window. Acceptance raises `pass`, which sends the receiver into its receive mode. Any gap that is too short or too long raises `fail`, which sends the receiver back to sleep.

An interval is the number of sample ticks from one edge tick to the next. An edge is any change of `din` between two successive ticks, rising or falling. The first edge after start-up only starts the timing. A verdict holds until `enable` is removed. Dropping `enable` returns the block to idle within one clock.

Top module: `edge_window_check`

## Requirements
- R1: While `rst_n` is low, or on the clock after a cycle in which `enable` is low, `pass`, `fail` and `checking` are all 0. The block then waits in idle.
- R2: After `enable` rises, one clock enters start-up. `checking` goes to 1 after STARTUP_TICKS further ticks. Changes of `din` during start-up cause neither verdict.
- R3: The first edge seen in the check phase only starts interval timing and is never compared with the limits.
- R4: An edge whose interval is below `lim_lo` raises `fail` on the clock of that tick.
- R5: If no edge arrives and the interval count reaches `lim_hi` (lim_hi-1 ticks after the previous edge tick with no edge), `fail` rises on that tick's clock. The accepted range is lim_lo to lim_hi-1 ticks.
- R6: An edge landing on the tick where the count would reach `lim_hi` is accepted: the edge takes precedence over the upper-limit abort.
- R7: `edge_sel` sets the number of compared intervals needed for acceptance: 0 means 3, 1 means 6, and 2 or 3 means 9. `pass` rises on the clock of the tick of the last accepted edge, and not before.
- R8: `pass` and `fail` are never both 1. Once set, either one holds, whatever `din` does, until `enable` falls.
- R9: The interval counter and edge sampling advance only on clocks with `tick` high. Without ticks, the check phase neither times out nor ends.
- R10: Rising and falling edges of `din` count alike.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the block; low returns it to idle |
| tick | input | 1 | One-clock sample strobe, one per sample period |
| din | input | 1 | Demodulated data bit |
| lim_lo | input | CNT_W | Shortest accepted interval in ticks |
| lim_hi | input | CNT_W | Interval count that aborts the check (at most 63 by default) |
| edge_sel | input | 2 | Number of intervals to check: 0→3, 1→6, 2/3→9 |
| pass | output | 1 | Check passed: go to receive mode |
| fail | output | 1 | Check failed: go to sleep mode |
| checking | output | 1 | Check phase active |

## Verification
Two decisions can fall on one tick: an edge arriving and the interval count reaching `lim_hi`. The bench provokes this by placing an edge exactly lim_hi-1 ticks after the previous one. It then judges that the gap is accepted and that the check later reaches `pass`, not `fail`. A gap one tick longer must end in `fail`, and this is checked on the exact clock. A second coincidence, the removal of `enable` while a verdict stands, is judged by requiring that every output is clear on the next clock.

// File: rtl/edge_window_check.sv
module edge_window_check #(
  parameter int CNT_W         = 6,
  parameter int STARTUP_TICKS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             tick,
  input  logic             din,
  input  logic [CNT_W-1:0] lim_lo,
  input  logic [CNT_W-1:0] lim_hi,
  input  logic [1:0]       edge_sel,
  output logic             pass,
  output logic             fail,
  output logic             checking
);
  localparam int SU_W = $clog2(STARTUP_TICKS + 1);
  localparam int N_W  = 4;
  localparam logic [SU_W-1:0] SU_LAST = SU_W'(STARTUP_TICKS - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_CHECK, S_PASS, S_FAIL} state_t;

  state_t           state;
  logic [SU_W-1:0]  su_cnt;
  logic [CNT_W-1:0] cnt;
  logic [N_W-1:0]   n_ok;
  logic             armed;
  logic             prev;

  logic [N_W-1:0]   target;
  logic             edge_seen, too_early, hit_hi, last_edge;

  always_comb
    case (edge_sel)
      2'd0:    target = N_W'(3);
      2'd1:    target = N_W'(6);
      default: target = N_W'(9);
    endcase

  assign edge_seen = din ^ prev;
  assign too_early = cnt < lim_lo;
  assign hit_hi    = ({1'b0, cnt} + 1'b1) >= {1'b0, lim_hi};
  assign last_edge = (n_ok + 1'b1) == target;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state  <= S_IDLE;
      su_cnt <= '0;
      cnt    <= '0;
      n_ok   <= '0;
      armed  <= 1'b0;
      prev   <= 1'b0;
    end else if (!enable) begin
      state  <= S_IDLE;
      su_cnt <= '0;
      cnt    <= '0;
      n_ok   <= '0;
      armed  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          state  <= S_START;
          su_cnt <= '0;
        end
        S_START:
          if (tick) begin
            if (su_cnt == SU_LAST) begin
              state <= S_CHECK;
              prev  <= din;
              cnt   <= '0;
              n_ok  <= '0;
              armed <= 1'b0;
            end else
              su_cnt <= su_cnt + 1'b1;
          end
        S_CHECK:
          if (tick) begin
            prev <= din;
            if (edge_seen) begin
              if (!armed) begin
                armed <= 1'b1;
                cnt   <= CNT_W'(1);
              end else if (too_early)
                state <= S_FAIL;
              else begin
                cnt  <= CNT_W'(1);
                n_ok <= n_ok + 1'b1;
                if (last_edge) state <= S_PASS;
              end
            end else if (armed) begin
              if (hit_hi) state <= S_FAIL;
              else        cnt   <= cnt + 1'b1;
            end
          end
        default: ;
      endcase
    end

  assign pass     = state == S_PASS;
  assign fail     = state == S_FAIL;
  assign checking = state == S_CHECK;
endmodule

// File: rtl/edge_window_check_props.sv
module edge_window_check_props (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic tick,
  input logic pass,
  input logic fail,
  input logic checking
);
  p_verdict_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass && fail));

  p_pass_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pass && enable) |=> pass);

  p_fail_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && enable) |=> fail);

  p_idle_on_disable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!pass && !fail && !checking));

  p_fail_from_check_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> $past(checking && tick));

  p_pass_from_check_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pass) |-> $past(checking && tick));

  p_no_tick_no_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (checking && !tick && enable) |=> checking);
endmodule

bind edge_window_check edge_window_check_props u_props (
  .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
  .pass(pass), .fail(fail), .checking(checking)
);

// File: tb/test_edge_window_check.sv
`timescale 1ns/1ps
module test_edge_window_check;
  localparam int SU = 8;

  logic clk = 0, rst_n = 0, enable = 0, tick = 1, din = 0;
  logic [5:0] lim_lo = 6'd10, lim_hi = 6'd20;
  logic [1:0] edge_sel = 2'd0;
  logic pass, fail, checking;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  edge_window_check #(.CNT_W(6), .STARTUP_TICKS(SU)) i_edge_window_check (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick), .din(din),
    .lim_lo(lim_lo), .lim_hi(lim_hi), .edge_sel(edge_sel),
    .pass(pass), .fail(fail), .checking(checking));

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic start(input int lo, input int hi, input int sel);
    @(negedge clk); enable = 0; tick = 1;
    @(negedge clk);
    lim_lo = 6'(lo); lim_hi = 6'(hi); edge_sel = 2'(sel);
    enable = 1;
    repeat (SU + 1) @(negedge clk);
  endtask

  task automatic edge_after(input int n);
    repeat (n) @(negedge clk);
    din = ~din;
  endtask

  task automatic t_reset;
    #1;
    chk("R1", "pass in reset", pass, 0);
    chk("R1", "fail in reset", fail, 0);
    chk("R1", "checking in reset", checking, 0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "checking while disabled", checking, 0);
  endtask

  task automatic t_startup;
    @(negedge clk); enable = 0;
    @(negedge clk); lim_lo = 10; lim_hi = 20; edge_sel = 0; enable = 1;
    for (int i = 0; i < SU; i++) begin
      @(negedge clk); din = ~din;
    end
    chk("R2", "checking before start-up end", checking, 0);
    chk("R2", "fail during start-up", fail, 0);
    @(negedge clk);
    chk("R2", "checking after start-up", checking, 1);
    chk("R2", "no verdict from start-up noise", pass | fail, 0);
  endtask

  task automatic t_arm_and_early;
    start(10, 20, 0);
    din = ~din;
    @(negedge clk);
    chk("R3", "first edge only arms", fail, 0);
    edge_after(8);
    @(negedge clk);
    chk("R4", "interval 9 below lim_lo", fail, 1);
    chk("R8", "no pass with fail", pass, 0);
  endtask

  task automatic t_timeout;
    start(10, 20, 0);
    din = ~din;
    repeat (19) @(negedge clk);
    chk("R5", "fail before upper limit", fail, 0);
    @(negedge clk);
    chk("R5", "fail when count reaches lim_hi", fail, 1);
  endtask

  task automatic t_window_pass;
    start(10, 20, 0);
    din = ~din;
    edge_after(10);
    edge_after(19);
    edge_after(15);
    @(negedge clk);
    chk("R6", "edge at lim_hi-1 accepted, pass after 3", pass, 1);
    chk("R10", "rising and falling both counted", fail, 0);
    repeat (3) begin @(negedge clk); din = ~din; end
    repeat (30) @(negedge clk);
    chk("R8", "pass held under noise", pass, 1);
    chk("R8", "no fail after pass", fail, 0);
    enable = 0;
    @(negedge clk);
    chk("R1", "pass cleared by disable", pass, 0);
  endtask

  task automatic t_count(input int sel, input int need);
    start(10, 20, sel);
    din = ~din;
    for (int i = 0; i < need - 1; i++) edge_after(12);
    @(negedge clk);
    chk("R7", $sformatf("no pass one short, sel %0d", sel), pass, 0);
    edge_after(11);
    @(negedge clk);
    chk("R7", $sformatf("pass after %0d intervals", need), pass, 1);
  endtask

  task automatic t_tick_gate;
    start(10, 20, 0);
    din = ~din;
    @(negedge clk); tick = 0;
    repeat (100) @(negedge clk);
    chk("R9", "no timeout without ticks", fail, 0);
    chk("R9", "still checking without ticks", checking, 1);
    tick = 1;
    repeat (9) @(negedge clk);
    din = ~din;
    @(negedge clk);
    chk("R9", "interval counted in ticks only", fail, 0);
    enable = 0;
    @(negedge clk);
    chk("R1", "checking cleared by disable", checking, 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_startup();
    t_arm_and_early();
    t_timeout();
    t_window_pass();
    t_count(0, 3);
    t_count(1, 6);
    t_count(2, 9);
    t_count(3, 9);
    t_tick_gate();
    finish_run();
  end
endmodule